// File: doc/BRIEF.md
# Byte-Lane Static Memory with Supply-Fail Protection

This block is a clocked, cycle-level model of a 16-bit static memory whose two byte halves each have an active-low select. Active-low write and output-enable inputs complete the control set. At every rising clock edge the block classifies the sampled controls as a read, a write or an idle cycle. A write stores only the byte halves whose selects are low. A read returns the selected halves one edge later. Tri-state pins are replaced by a per-lane drive flag next to a data bus that carries zeros wherever its lane is not driving.

A supply-fail input write-protects the array while it is high. During that time every control and data input is ignored and all outputs are forced off at once. Stored data is kept through the fail period and is not cleared when it ends. The delay between the write enable going low and the outputs turning off is a parameter, counted in clock edges.

The word count is 2^ADDR_W. A full-size instance sets ADDR_W to 17, which gives 131,072 words. The default is kept small so that elaboration stays light. Contents after reset are undefined.

Top module: `dual_lane_sram`

## Requirements
- R1: When the write enable is low and both byte selects are low, the edge stores the full 16-bit input word at the address, and a later read of that address returns it.
- R2: A write with only one byte select low changes only that lane: bits 15:8 belong to the upper select (lane_ce_n[1]), and bits 7:0 belong to the lower select (lane_ce_n[0]). The other lane keeps its old value.
- R3: An edge that samples write enable high, output enable low and a byte select low makes that lane's drive flag 1 after the edge, with the stored byte on its slice of dout.
- R4: During a read, a lane whose select is high has drive flag 0 after the edge and zeros on its slice of dout.
- R5: An edge that samples the output enable high, or both byte selects high, while the write enable is high leaves both drive flags 0 and dout all zeros.
- R6: A write happens whatever the output enable level. With OFF_DLY = 1, the first edge that samples the write enable low turns every drive flag off.
- R7: While pfail is 1, drv and dout are 0 in the same cycle, without waiting for a clock edge.
- R8: An edge sampled with pfail at 1 changes no stored byte, whatever the other inputs are.
- R9: After pfail returns to 0, reads return the contents held before the fail period.
- R10: After an edge with rst high, drv is 0 and dout is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of output state |
| lane_ce_n | input | LANES (2) | Active-low byte selects; bit 1 upper, bit 0 lower |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| pfail | input | 1 | Supply-fail: write-protect and force outputs off |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data; zero in lanes not driving |
| drv | output | LANES | Per-lane drive flag standing in for the output drivers |

## Verification
The properties assume that every input is a known value at each rising edge after reset and does not change within a cycle. They also assume the default one-edge output-off delay: the write-turn-off property is only generated when OFF_DLY is 1. The bench respects these assumptions. It changes inputs one nanosecond after each edge, drives every input to a defined level from time zero, and fills the whole array before any read. Because of the fill, every data comparison in the reference model is against a known byte.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/access_decode.sv
module access_decode
  import dls_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0] lane_ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             pfail,
  output acc_e             acc,
  output logic [LANES-1:0] lane_sel
);
  always_comb begin
    lane_sel = ~lane_ce_n;
    acc      = ACC_IDLE;
    // Supply fail masks every control; write enable wins over output enable.
    if (!pfail && (|lane_sel)) begin
      if (!we_n)      acc = ACC_WRITE;
      else if (!oe_n) acc = ACC_READ;
    end
  end
endmodule

// File: rtl/byte_lane_ram.sv
module byte_lane_ram #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              hold,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata,
  output logic              valid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // Plain single-port pattern so a block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst)        valid <= 1'b0;
    else if (rd_en) valid <= 1'b1;
    else if (hold)  valid <= valid;
    else            valid <= 1'b0;
  end
endmodule

// File: rtl/drive_hold.sv
module drive_hold
  import dls_pkg::*;
#(
  parameter int OFF_DLY = 1
) (
  input  logic clk,
  input  logic rst,
  input  acc_e acc,
  output logic hold
);
  localparam int CW = (OFF_DLY > 1) ? $clog2(OFF_DLY + 1) : 1;

  logic [CW-1:0] cnt;

  // Outputs linger only across write cycles, for OFF_DLY-1 edges after a read.
  assign hold = (acc == ACC_WRITE) && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (acc == ACC_READ)  cnt <= CW'(OFF_DLY - 1);
    else if (cnt != '0)        cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/dual_lane_sram.sv
module dual_lane_sram
  import dls_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int OFF_DLY = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        lane_ce_n,
  input  logic                    we_n,
  input  logic                    oe_n,
  input  logic                    pfail,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic [LANES-1:0]        drv
);
  acc_e             acc;
  logic [LANES-1:0] lane_sel;
  logic             hold;

  access_decode #(.LANES(LANES)) u_dec (
    .lane_ce_n (lane_ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .pfail     (pfail),
    .acc       (acc),
    .lane_sel  (lane_sel)
  );

  drive_hold #(.OFF_DLY(OFF_DLY)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .acc  (acc),
    .hold (hold)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] q;
    logic              vld;

    byte_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
      .clk   (clk),
      .rst   (rst),
      .wr_en (acc == ACC_WRITE && lane_sel[l]),
      .rd_en (acc == ACC_READ && lane_sel[l]),
      .hold  (hold),
      .addr  (addr),
      .wdata (din[l*LANE_W +: LANE_W]),
      .rdata (q),
      .valid (vld)
    );

    // Supply fail turns the lane off without waiting for an edge.
    assign drv[l]                  = vld & ~pfail;
    assign dout[l*LANE_W +: LANE_W] = drv[l] ? q : '0;
  end
endmodule

// File: rtl/dual_lane_sram_chk.sv
module dual_lane_sram_chk #(
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int OFF_DLY = 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LANES-1:0]        lane_ce_n,
  input logic                    we_n,
  input logic                    oe_n,
  input logic                    pfail,
  input logic [LANES*LANE_W-1:0] dout,
  input logic [LANES-1:0]        drv
);
  p_pfail_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    pfail |-> (drv == '0 && dout == '0));

  p_idle_off_r5: assert property (@(posedge clk) disable iff (rst)
    (we_n && (oe_n || (&lane_ce_n))) |=> (drv == '0));

  p_reset_off_r10: assert property (@(posedge clk)
    rst |=> (drv == '0 && dout == '0));

  if (OFF_DLY == 1) begin : g_fast_off
    p_write_off_r6: assert property (@(posedge clk) disable iff (rst)
      !we_n |=> (drv == '0));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    p_read_drives_r3: assert property (@(posedge clk) disable iff (rst)
      (we_n && !oe_n && !lane_ce_n[l] && !pfail) |=> (pfail || drv[l]));

    p_unsel_off_r4: assert property (@(posedge clk) disable iff (rst)
      (we_n && lane_ce_n[l]) |=> !drv[l]);

    p_zero_when_off_r4: assert property (@(posedge clk) disable iff (rst)
      !drv[l] |-> (dout[l*LANE_W +: LANE_W] == '0));
  end
endmodule

bind dual_lane_sram dual_lane_sram_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .OFF_DLY(OFF_DLY)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lane_ce_n (lane_ce_n),
  .we_n      (we_n),
  .oe_n      (oe_n),
  .pfail     (pfail),
  .dout      (dout),
  .drv       (drv)
);

// File: tb/sim_dual_lane_sram.sv
`timescale 1ns/1ps
module sim_dual_lane_sram;
  localparam int AW  = 10;
  localparam int DW  = 16;
  localparam int DLY = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    ce_n = 2'b11;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          pfail = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic [1:0]    drv;

  int n_cmp = 0;
  int n_bad = 0;

  logic [DW-1:0] ref_mem [1 << AW];
  logic [1:0]    e_drv = 2'b00;
  logic [DW-1:0] e_q = '0;
  int            hold = 0;

  always #2.5 clk = ~clk;

  dual_lane_sram #(.ADDR_W(AW), .OFF_DLY(DLY)) u0 (
    .clk(clk), .rst(rst), .lane_ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .pfail(pfail), .addr(addr), .din(din), .dout(dout), .drv(drv)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 40503) ^ 16'hC3A5);
  endfunction

  task automatic compare(input string tag);
    logic [1:0]    x_drv;
    logic [DW-1:0] x_dout;
    x_drv = pfail ? 2'b00 : e_drv;
    for (int l = 0; l < 2; l++)
      x_dout[l*8 +: 8] = x_drv[l] ? e_q[l*8 +: 8] : 8'h00;
    n_cmp++;
    if (drv !== x_drv || dout !== x_dout) begin
      n_bad++;
      $display("FAIL %s: drv=%b dout=%h expected drv=%b dout=%h",
               tag, drv, dout, x_drv, x_dout);
    end
  endtask

  task automatic step(input logic r, input logic [1:0] c, input logic w,
                      input logic o, input logic p, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string tag);
    rst = r; ce_n = c; we_n = w; oe_n = o; pfail = p; addr = a; din = d;
    @(posedge clk);
    if (r) begin
      e_drv = 2'b00; hold = 0;
    end else if (!p && !w && c != 2'b11) begin
      for (int l = 0; l < 2; l++)
        if (!c[l]) ref_mem[a][l*8 +: 8] = d[l*8 +: 8];
      if (hold != 0) hold--;
      else e_drv = 2'b00;
    end else if (!p && w && !o && c != 2'b11) begin
      for (int l = 0; l < 2; l++) begin
        e_drv[l] = !c[l];
        if (!c[l]) e_q[l*8 +: 8] = ref_mem[a][l*8 +: 8];
      end
      hold = DLY - 1;
    end else begin
      e_drv = 2'b00;
      if (hold != 0) hold--;
    end
    #1;
    compare(tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    step(1, 2'b11, 1, 1, 0, '0, '0, "R10");
    step(1, 2'b00, 1, 0, 0, '0, '0, "R10");
    // R1: fill every word with full-width writes
    for (int i = 0; i < (1 << AW); i++)
      step(0, 2'b00, 0, 1, 0, AW'(i), pat(i), "R1");
    for (int i = 0; i < 8; i++)
      step(0, 2'b00, 1, 0, 0, AW'(i * 97), '0, "R1");
    // R2: upper-only write, then full read shows old lower byte
    step(0, 2'b01, 0, 1, 0, AW'(5), 16'hABCD, "R2");
    step(0, 2'b00, 1, 0, 0, AW'(5), '0, "R2");
    step(0, 2'b10, 0, 1, 0, AW'(6), 16'h1234, "R2");
    step(0, 2'b00, 1, 0, 0, AW'(6), '0, "R2");
    // R4: single-lane reads
    step(0, 2'b01, 1, 0, 0, AW'(5), '0, "R4");
    step(0, 2'b10, 1, 0, 0, AW'(6), '0, "R4");
    // R3: full read
    step(0, 2'b00, 1, 0, 0, AW'(300), '0, "R3");
    // R5: output enable high, then both selects high
    step(0, 2'b00, 1, 1, 0, AW'(300), '0, "R5");
    step(0, 2'b00, 1, 0, 0, AW'(301), '0, "R3");
    step(0, 2'b11, 1, 0, 0, AW'(301), '0, "R5");
    // R6: read, then write with output enable still low
    step(0, 2'b00, 1, 0, 0, AW'(7), '0, "R3");
    step(0, 2'b00, 0, 0, 0, AW'(7), 16'h5EED, "R6");
    step(0, 2'b00, 1, 0, 0, AW'(7), '0, "R6");
    // R7/R8: drive outputs, then supply fail with write attempts
    step(0, 2'b00, 1, 0, 0, AW'(9), '0, "R3");
    step(0, 2'b00, 0, 0, 1, AW'(9), 16'hDEAD, "R7");
    step(0, 2'b00, 1, 0, 1, AW'(9), '0, "R7");
    step(0, 2'b01, 0, 1, 1, AW'(10), 16'hBEEF, "R8");
    // R9: contents survive after release
    step(0, 2'b00, 1, 0, 0, AW'(9), '0, "R9");
    step(0, 2'b00, 1, 0, 0, AW'(10), '0, "R8");
    step(0, 2'b00, 1, 0, 0, AW'(5), '0, "R9");
    // Mixed traffic
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] c;
      logic w, o, p;
      string tg;
      c = 2'($urandom % 4);
      w = ($urandom % 3) != 0;
      o = ($urandom % 4) == 0;
      p = ($urandom % 16) == 0;
      tg = p ? "R7" : (!w && c != 2'b11) ? "R6" :
           (w && !o && c != 2'b11) ? "R3" : "R5";
      step(0, c, w, o, p, AW'($urandom), DW'($urandom), tg);
    end
    summary();
    $finish;
  end
endmodule